// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives six PWM pins, a positive pin and a negative pin for each of three phases, from a symmetric triangle carrier. Two up/down counters run one dead-time value apart. The positive pin of a phase compares the lower counter with that phase's duty value. The negative pin compares the upper counter with the same duty value. This offset keeps the two pins of a phase apart by exactly the dead time, with no separate delay timers on each edge.

Software writes staging buffers through a simple write port: the upper-counter limit, the half carrier period and three duties. It also writes the dead time and a pair of polarity bits directly. Raising `run_en` moves the controller from `ST_IDLE` to `ST_XFER`. In that single transfer cycle all five staging buffers are copied into the working compare registers, and both counters are loaded with their start values. The controller then alternates between `ST_UP` and `ST_DOWN`. Dropping `run_en` returns it to `ST_IDLE` from any state. The transitions are: idle-to-transfer on `run_en`, transfer-to-up, up-to-down when a counter reaches its limit, down-to-up when the lower counter reaches zero, and any-to-idle when `run_en` is low.

Top module: `cpwm3_top`

## Requirements
- R1: After reset all six pins are low, both polarity bits are 1 (active-high), and the controller is in `ST_IDLE`.
- R2: A write takes effect at the clock edge where `wr_en` is high. The address map is: 0 upper-counter limit, 1 half period, 2 dead time Td, 3 polarity (bit 0 sets the positive pins, bit 1 sets the negative pins), 4/5/6 duty of phase 0/1/2.
- R3: The first edge with `run_en` high enters `ST_XFER`, during which all pins are inactive. At the next edge all five staging buffers are copied together, the lower counter is set to 0 and the upper counter is set to Td.
- R4: While counting, the lower counter follows a triangle from 0 up to the half period and back to 0, one step per clock, with a carrier period of twice the half period (half period of at least 1).
- R5: While counting, the upper counter always equals the lower counter plus Td. Both counters reverse direction on the same clock.
- R6: A positive output is active exactly while the lower counter is greater than or equal to that phase's duty.
- R7: A negative output is active exactly while the upper counter is below that phase's duty.
- R8: The two outputs of a phase are never active together. On the rising slope, when Td < duty <= half period, the positive output becomes active exactly Td clocks after the negative output goes inactive.
- R9: A polarity bit of 1 makes its group of pins active-high, and 0 makes it active-low. Inactive pins sit at the inverse of the bit.
- R10: One edge after `run_en` is seen low, the controller is in `ST_IDLE` and all six pins are at their inactive level.
- R11: Writes to the dead time and polarity bits are ignored while `run_en` is high. Staging-buffer writes made while running change nothing until the next mode entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Mode enable; rising level starts transfer and counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R2) |
| wr_data | input | CW (16) | Register write data |
| pwm_p | output | NPH (3) | Positive-side pins, one per phase |
| pwm_n | output | NPH (3) | Negative-side pins, one per phase |

## Verification
Register writes land at the edge where the strobe is sampled. The transfer cycle is visible one edge after `run_en` is sampled high. Counting index 0 appears one edge after that. Because the pins are decoded combinationally from the registered counters, each pin value is due in the same cycle as its counter value. A disable shows inactive pins one edge after `run_en` drops. The bench drives and samples only on falling edges. It advances its own triangle index by exactly one per edge, including the edges consumed by mid-run writes, so every expected pin value is compared in the cycle it is due.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_UP   = 2'd2,
        ST_DOWN = 2'd3
    } cpwm_state_e;

    localparam int AW         = 3;
    localparam int ADDR_PEAK  = 0;
    localparam int ADDR_HALF  = 1;
    localparam int ADDR_DEAD  = 2;
    localparam int ADDR_LVL   = 3;
    localparam int ADDR_DUTY0 = 4;

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [CW-1:0]           wr_data,
    input  logic                    lock,
    input  logic                    xfer,
    output logic [CW-1:0]           peak_c,
    output logic [CW-1:0]           half_c,
    output logic [CW-1:0]           dead_r,
    output logic [NPH-1:0][CW-1:0]  duty_c,
    output logic                    lvl_p,
    output logic                    lvl_n
);

    logic [CW-1:0] peak_b;
    logic [CW-1:0] half_b;

    // staging buffers and the directly written, lock-protected fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_b <= '0;
            half_b <= '0;
            dead_r <= '0;
            lvl_p  <= 1'b1;
            lvl_n  <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                AW'(ADDR_PEAK): peak_b <= wr_data;
                AW'(ADDR_HALF): half_b <= wr_data;
                AW'(ADDR_DEAD): begin
                    if (!lock) dead_r <= wr_data;
                end
                AW'(ADDR_LVL): begin
                    if (!lock) begin
                        lvl_p <= wr_data[0];
                        lvl_n <= wr_data[1];
                    end
                end
                default: ;
            endcase
        end
    end

    // working compare registers for the carrier limits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_c <= '0;
            half_c <= '0;
        end else if (xfer) begin
            peak_c <= peak_b;
            half_c <= half_b;
        end
    end

    // per-phase duty buffer and compare register
    for (genvar g = 0; g < NPH; g++) begin : g_duty
        logic [CW-1:0] duty_b;
        logic [CW-1:0] duty_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_b <= '0;
            end else if (wr_en && (wr_addr == AW'(ADDR_DUTY0 + g))) begin
                duty_b <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_q <= '0;
            end else if (xfer) begin
                duty_q <= duty_b;
            end
        end

        assign duty_c[g] = duty_q;
    end

endmodule

// File: rtl/cpwm_seq.sv
module cpwm_seq
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [CW-1:0] dead,
    input  logic [CW-1:0] peak_c,
    input  logic [CW-1:0] half_c,
    output cpwm_state_e   state,
    output logic [CW-1:0] ctr_lo,
    output logic [CW-1:0] ctr_hi,
    output logic          xfer,
    output logic          counting
);

    localparam int EW = CW + 1;

    cpwm_state_e state_q;
    cpwm_state_e state_d;

    logic [EW-1:0] lo_inc;
    logic [EW-1:0] hi_inc;
    logic          top_hit;
    logic          bot_hit;

    assign lo_inc  = {1'b0, ctr_lo} + EW'(1);
    assign hi_inc  = {1'b0, ctr_hi} + EW'(1);
    assign top_hit = (lo_inc >= {1'b0, half_c}) || (hi_inc >= {1'b0, peak_c});
    assign bot_hit = (ctr_lo <= CW'(1));

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = run_en ? ST_XFER : ST_IDLE;
            ST_XFER: state_d = run_en ? ST_UP   : ST_IDLE;
            ST_UP: begin
                if (!run_en)      state_d = ST_IDLE;
                else if (top_hit) state_d = ST_DOWN;
            end
            ST_DOWN: begin
                if (!run_en)      state_d = ST_IDLE;
                else if (bot_hit) state_d = ST_UP;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter pair, stepped together so they stay Td apart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_lo <= '0;
            ctr_hi <= '0;
        end else begin
            unique case (state_q)
                ST_XFER: begin
                    if (run_en) begin
                        ctr_lo <= '0;
                        ctr_hi <= dead;
                    end
                end
                ST_UP: begin
                    if (run_en) begin
                        ctr_lo <= ctr_lo + CW'(1);
                        ctr_hi <= ctr_hi + CW'(1);
                    end
                end
                ST_DOWN: begin
                    if (run_en) begin
                        ctr_lo <= ctr_lo - CW'(1);
                        ctr_hi <= ctr_hi - CW'(1);
                    end
                end
                ST_IDLE: ;
            endcase
        end
    end

    assign state    = state_q;
    assign xfer     = (state_q == ST_XFER);
    assign counting = (state_q == ST_UP) || (state_q == ST_DOWN);

endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
    parameter int CW = 16
) (
    input  logic          counting,
    input  logic [CW-1:0] ctr_lo,
    input  logic [CW-1:0] ctr_hi,
    input  logic [CW-1:0] duty,
    input  logic          lvl_p,
    input  logic          lvl_n,
    output logic          act_p,
    output logic          act_n,
    output logic          pin_p,
    output logic          pin_n
);

    // positive side keyed to the lower counter, negative side to the upper
    assign act_p = counting && (ctr_lo >= duty);
    assign act_n = counting && (ctr_hi <  duty);

    assign pin_p = act_p ? lvl_p : ~lvl_p;
    assign pin_n = act_n ? lvl_n : ~lvl_n;

endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top
    import cpwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NPH-1:0] pwm_p,
    output logic [NPH-1:0] pwm_n
);

    logic [CW-1:0]          peak_c;
    logic [CW-1:0]          half_c;
    logic [CW-1:0]          dead_r;
    logic [NPH-1:0][CW-1:0] duty_c;
    logic                   lvl_p;
    logic                   lvl_n;
    cpwm_state_e            state;
    logic [CW-1:0]          ctr_lo;
    logic [CW-1:0]          ctr_hi;
    logic                   xfer;
    logic                   counting;
    logic [NPH-1:0]         act_p;
    logic [NPH-1:0]         act_n;

    cpwm_regs #(.CW(CW), .NPH(NPH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lock    (run_en),
        .xfer    (xfer),
        .peak_c  (peak_c),
        .half_c  (half_c),
        .dead_r  (dead_r),
        .duty_c  (duty_c),
        .lvl_p   (lvl_p),
        .lvl_n   (lvl_n)
    );

    cpwm_seq #(.CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .dead     (dead_r),
        .peak_c   (peak_c),
        .half_c   (half_c),
        .state    (state),
        .ctr_lo   (ctr_lo),
        .ctr_hi   (ctr_hi),
        .xfer     (xfer),
        .counting (counting)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        cpwm_phase #(.CW(CW)) u_phase (
            .counting (counting),
            .ctr_lo   (ctr_lo),
            .ctr_hi   (ctr_hi),
            .duty     (duty_c[g]),
            .lvl_p    (lvl_p),
            .lvl_n    (lvl_n),
            .act_p    (act_p[g]),
            .act_n    (act_n[g]),
            .pin_p    (pwm_p[g]),
            .pin_n    (pwm_n[g])
        );
    end

endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk
    import cpwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run_en,
    input cpwm_state_e    state,
    input logic [CW-1:0]  ctr_lo,
    input logic [CW-1:0]  ctr_hi,
    input logic [CW-1:0]  dead,
    input logic [NPH-1:0] act_p,
    input logic [NPH-1:0] act_n
);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_p & act_n) == '0); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (act_p == '0 && act_n == '0)); // R10

    AST_OFF_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state == ST_IDLE)); // R10

    AST_XFER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && run_en) |=> (ctr_lo == '0 && ctr_hi == dead)); // R3

    AST_CTR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UP || state == ST_DOWN) |-> (ctr_hi == ctr_lo + dead)); // R5

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_UP || state == ST_DOWN) && run_en) |=>
        (ctr_lo == $past(ctr_lo) + CW'(1) || ctr_lo == $past(ctr_lo) - CW'(1))); // R4

    AST_DEAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en) |-> $stable(dead)); // R11

endmodule

bind cpwm3_top cpwm_chk #(.CW(CW), .NPH(NPH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .state  (state),
    .ctr_lo (ctr_lo),
    .ctr_hi (ctr_hi),
    .dead   (dead_r),
    .act_p  (act_p),
    .act_n  (act_n)
);

// File: tb/cpwm3_top_tb.sv
`timescale 1ns/1ps
module cpwm3_top_tb;

    localparam int CW  = 16;
    localparam int NPH = 3;

    // stimulus vectors: half period, Td, duty0, duty1, duty2, polarity bits
    localparam int NVEC = 4;
    localparam int VEC [NVEC][6] = '{
        '{10, 2, 4, 6, 9, 3},
        '{ 8, 3, 0, 5, 8, 0},
        '{12, 0, 3, 7, 12, 1},
        '{ 6, 1, 2, 20, 4, 2}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run_en = 1'b0;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic [NPH-1:0] pwm_p;
    logic [NPH-1:0] pwm_n;

    int checks = 0;
    int errors = 0;

    // bench model of the active configuration
    int   m_cyc = 1;
    int   m_td  = 0;
    int   m_d [NPH];
    logic m_lp  = 1'b1;
    logic m_ln  = 1'b1;
    int   fall_at [NPH];

    always #4 clk = ~clk;

    cpwm3_top #(.CW(CW), .NPH(NPH)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_p   (pwm_p),
        .pwm_n   (pwm_n)
    );

    function automatic int tri_b(input int n);
        int m;
        m = n % (2 * m_cyc);
        return (m <= m_cyc) ? m : (2 * m_cyc - m);
    endfunction

    task automatic cmp(input string tag, input logic [NPH-1:0] act, input logic [NPH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_addr = addr[2:0];
        wr_data = data[CW-1:0];
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        cmp({tag, " pos"}, pwm_p, {NPH{~m_lp}});
        cmp({tag, " neg"}, pwm_n, {NPH{~m_ln}});
    endtask

    // R2: address map 0 limit, 1 half, 2 Td, 3 polarity, 4..6 duties
    task automatic load_vec(input int cyc, input int td, input int d0, input int d1,
                            input int d2, input int lvl);
        wr(0, cyc + td);
        wr(1, cyc);
        wr(2, td);
        wr(3, lvl);
        wr(4, d0);
        wr(5, d1);
        wr(6, d2);
        m_cyc = cyc; m_td = td;
        m_d[0] = d0; m_d[1] = d1; m_d[2] = d2;
        m_lp = lvl[0]; m_ln = lvl[1];
        check_idle("R2 R9 idle level after load");
    endtask

    task automatic enable_run();
        run_en = 1'b1;
        @(negedge clk);
        check_idle("R3 transfer cycle");
        @(negedge clk);
        for (int i = 0; i < NPH; i++) fall_at[i] = -1;
    endtask

    task automatic disable_run();
        run_en = 1'b0;
        @(negedge clk);
        check_idle("R10 one edge after disable");
    endtask

    task automatic run_cycles(input int n0, input int cnt);
        logic [NPH-1:0] ep, en, ap, an, pp, pn;
        pp = '0;
        pn = '0;
        for (int k = 0; k < cnt; k++) begin
            int n, b, a;
            n = n0 + k;
            b = tri_b(n);
            a = b + m_td;
            for (int i = 0; i < NPH; i++) begin
                ep[i] = (b >= m_d[i]) ? m_lp : ~m_lp;
                en[i] = (a <  m_d[i]) ? m_ln : ~m_ln;
            end
            cmp($sformatf("R4 R5 R6 R9 pos n=%0d", n), pwm_p, ep);
            cmp($sformatf("R4 R5 R7 R9 neg n=%0d", n), pwm_n, en);
            ap = pwm_p ~^ {NPH{m_lp}};
            an = pwm_n ~^ {NPH{m_ln}};
            cmp($sformatf("R8 overlap n=%0d", n), ap & an, '0);
            if (k > 0) begin
                for (int i = 0; i < NPH; i++) begin
                    if (pn[i] && !an[i]) fall_at[i] = n;
                    if (!pp[i] && ap[i] && fall_at[i] >= 0) begin
                        checks++;
                        if (n - fall_at[i] != m_td) begin
                            errors++;
                            $display("FAIL R8 dead gap phase %0d actual=%0d expected=%0d",
                                     i, n - fall_at[i], m_td);
                        end
                        fall_at[i] = -1;
                    end
                end
            end
            pp = ap;
            pn = an;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPH; i++) begin
            m_d[i] = 0;
            fall_at[i] = -1;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        cmp("R1 pos during reset", pwm_p, '0);
        cmp("R1 neg during reset", pwm_n, '0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 pos after reset", pwm_p, '0);
        cmp("R1 neg after reset", pwm_n, '0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            load_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            enable_run();
            run_cycles(0, 6 * VEC[v][0] + 3);
            disable_run();
        end

        // R11 and R3: writes made while running
        load_vec(10, 2, 4, 6, 9, 3);
        enable_run();
        run_cycles(0, 15);
        wr(2, 5);      // Td write while running: ignored (R11)
        run_cycles(16, 3);
        wr(3, 0);      // polarity write while running: ignored (R11)
        run_cycles(20, 3);
        wr(4, 7);      // duty buffer write: no effect until re-entry (R11)
        run_cycles(24, 25);
        disable_run();
        // re-entry: old Td and polarity kept, new duty0 transferred (R3 R11)
        m_d[0] = 7;
        enable_run();
        run_cycles(0, 25);
        disable_run();

        // R9 R11: polarity write accepted while idle
        wr(3, 0);
        m_lp = 1'b0;
        m_ln = 1'b0;
        check_idle("R9 R11 idle polarity write accepted");

        // R10: disable during the transfer cycle
        run_en = 1'b1;
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check_idle("R10 disable from transfer");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule